// File: doc/BRIEF.md
# Partitioned SIMD Lane Negation Unit

This block negates every lane of a 128-bit vector operand as a two's-complement integer. An arrangement code chooses the lane width and how many bits are active. The code is a 2-bit size field, a 1-bit Q field and a scalar-mode flag. The lane width is 8 shifted left by the size field, giving 8, 16, 32 or 64 bits. In vector mode Q chooses a 64-bit or a 128-bit active width. In scalar mode the block works on exactly one 64-bit lane.

The negation is one inverter-plus-increment carry chain built from 8-bit segments. The chain is cut at every boundary of the selected lane width. The result is truncated to the lane width, so the most negative lane value comes back unchanged.

Codes with no defined meaning raise an undefined flag instead of giving a result. The result, the flag and an output valid are registered. They appear one clock after an accepted input, whatever the data values are.

Top module: `simd_lane_negate`

## Requirements
- R1: The lane width is 8 << size (size=00: 8, 01: 16, 10: 32, 11: 64 bits). Lanes never exchange carries.
- R2: Each active lane of the result equals (0 - lane) modulo 2^width. A zero lane gives zero, and a lane holding only its sign bit gives itself.
- R3: In vector mode with q=0 and size other than 11, only bits [63:0] are active and result[127:64] is zero.
- R4: In vector mode with q=1, all 128 bits are active for every size, including size=11 (two 64-bit lanes).
- R5: Vector mode with size=11 and q=0 sets undef=1 and gives result zero.
- R6: In scalar mode with size=11, result[63:0] is the negation of operand[63:0] and result[127:64] is zero, whatever the value of q.
- R7: In scalar mode with size other than 11, undef=1 and result is zero.
- R8: When in_valid is high at a clock edge, result and undef are updated at that edge and out_valid is 1. Otherwise out_valid is 0 after the edge. Latency is always one cycle.
- R9: While reset is asserted, out_valid, undef and result are all zero.
- R10: A clock edge with in_valid low leaves result and undef unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand and arrangement are valid this cycle |
| scalar_mode | input | 1 | 1: single 64-bit lane mode |
| size_fld | input | 2 | Lane size code |
| q_fld | input | 1 | Vector width select (0: 64, 1: 128 bits) |
| operand | input | 128 | Source vector |
| out_valid | output | 1 | Registered result is fresh |
| result | output | 128 | Lane-wise negated vector |
| undef | output | 1 | Arrangement was illegal |

## Verification
The bench sweeps all sixteen combinations of mode, size and Q. For each one it sends operands with all lanes zero, all ones, only sign bits set, value one, and random values. A zero lane makes the increment carry run all the way through the lane. If the chain were not cut at the right boundary, that carry would leak into the next lane and corrupt it. A design that saturated, instead of wrapping, would turn the sign-bit-only pattern into the largest positive value. A design that missed the zeroing of the inactive half would leak negated upper bits in 64-bit arrangements. A design that missed the reserved or scalar-illegal codes would give a non-zero result with undef low. Cycles with in_valid low and a changed operand show whether the output register leaks new data when it should hold.

// File: rtl/neg_pkg.sv
// Shared types for the lane negation unit.
// Assumes a maximum lane width of 64 bits built from 8-bit segments.
package neg_pkg;
    localparam int unsigned SEG_W      = 8;
    localparam int unsigned MAX_LANE_W = 64;
    localparam int unsigned SPAN_W     = $clog2(MAX_LANE_W / SEG_W);

    typedef struct packed {
        logic       undef;      // arrangement has no defined meaning
        logic       wide;       // full 128 bits active
        logic [1:0] lane_code;  // log2(lane width / 8)
    } arr_dec_t;
endpackage

// File: rtl/neg_arr_decode.sv
// Decodes the mode, size and Q fields into lane code, active width and the undefined flag.
// Assumes scalar mode allows only one 64-bit lane and ignores Q.
module neg_arr_decode
    import neg_pkg::*;
(
    input  logic       scalar_mode,
    input  logic [1:0] size_fld,
    input  logic       q_fld,
    output arr_dec_t   dec
);
    // Pure decode of the arrangement fields.
    always_comb begin
        dec.lane_code = size_fld;
        if (scalar_mode) begin
            dec.wide  = 1'b0;
            dec.undef = (size_fld != 2'b11);
        end else begin
            dec.wide  = q_fld;
            dec.undef = (size_fld == 2'b11) && !q_fld;
        end
    end
endmodule

// File: rtl/neg_lane_array.sv
// Segmented inverter-plus-one chain. A segment restarts the carry with 1 when it
// begins a lane, and otherwise takes the carry from the segment below.
// Assumes DATA_W is a multiple of MAX_LANE_W.
module neg_lane_array
    import neg_pkg::*;
#(
    parameter int unsigned DATA_W = 128
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [1:0]        lane_code,
    output logic [DATA_W-1:0] negated
);
    localparam int unsigned NUM_SEG      = DATA_W / SEG_W;
    localparam int unsigned SEG_PER_LANE = MAX_LANE_W / SEG_W;

    logic [SPAN_W-1:0]  seg_mask;
    logic [NUM_SEG-1:0] cin;
    logic [NUM_SEG-1:0] cout;

    // Mask of segment-index bits that lie inside one lane.
    always_comb begin
        seg_mask = '0;
        for (int k = 0; k < SPAN_W; k++)
            if (k < int'(lane_code)) seg_mask[k] = 1'b1;
    end

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        localparam logic [SPAN_W-1:0] POS = SPAN_W'(i % SEG_PER_LANE);
        if (i == 0) begin : g_first
            assign cin[i] = 1'b1;
        end else begin : g_rest
            assign cin[i] = ((POS & seg_mask) == '0) ? 1'b1 : cout[i-1];
        end
        if (i == NUM_SEG - 1) begin : g_top
            assign negated[i*SEG_W +: SEG_W] = ~operand[i*SEG_W +: SEG_W] + SEG_W'(cin[i]);
            assign cout[i] = 1'b0;
        end else begin : g_mid
            assign {cout[i], negated[i*SEG_W +: SEG_W]} =
                {1'b0, ~operand[i*SEG_W +: SEG_W]} + (SEG_W+1)'(cin[i]);
        end
    end
endmodule

// File: rtl/neg_out_mask.sv
// Clears the inactive upper half, or the whole word when the arrangement is illegal.
// Assumes DATA_W is even.
module neg_out_mask
    import neg_pkg::*;
#(
    parameter int unsigned DATA_W = 128
) (
    input  logic [DATA_W-1:0] negated,
    input  arr_dec_t          dec,
    output logic [DATA_W-1:0] masked
);
    localparam int unsigned HALF_W = DATA_W / 2;

    // Select full, lower-half or zero result.
    always_comb begin
        if (dec.undef)     masked = '0;
        else if (dec.wide) masked = negated;
        else               masked = {{HALF_W{1'b0}}, negated[HALF_W-1:0]};
    end
endmodule

// File: rtl/simd_lane_negate.sv
// Top: decode, partitioned negate, mask, then one register stage.
// Assumes a synchronous active-low reset. The registers load only on in_valid.
module simd_lane_negate
    import neg_pkg::*;
#(
    parameter int unsigned DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              scalar_mode,
    input  logic [1:0]        size_fld,
    input  logic              q_fld,
    input  logic [DATA_W-1:0] operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              undef
);
    arr_dec_t          dec;
    logic [DATA_W-1:0] negated;
    logic [DATA_W-1:0] masked;

    neg_arr_decode u_dec (
        .scalar_mode (scalar_mode),
        .size_fld    (size_fld),
        .q_fld       (q_fld),
        .dec         (dec)
    );

    neg_lane_array #(.DATA_W(DATA_W)) u_arr (
        .operand   (operand),
        .lane_code (dec.lane_code),
        .negated   (negated)
    );

    neg_out_mask #(.DATA_W(DATA_W)) u_mask (
        .negated (negated),
        .dec     (dec),
        .masked  (masked)
    );

    // Output stage: valid tracks in_valid, data loads only on a valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            undef     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= masked;
                undef  <= dec.undef;
            end
        end
    end
endmodule

// File: rtl/neg_checker.sv
// Port-level properties of the lane negation unit, bound to the top module.
module neg_checker #(
    parameter int unsigned DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              scalar_mode,
    input logic [1:0]        size_fld,
    input logic              q_fld,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              undef
);
    localparam int unsigned HALF_W = DATA_W / 2;

    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_undef_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && undef) |-> (result == '0));
    assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !scalar_mode && size_fld == 2'b11 && !q_fld) |=> undef);
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !scalar_mode && !q_fld) |=> (result[DATA_W-1:HALF_W] == '0));
    assert_scalar_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scalar_mode) |=> (result[DATA_W-1:HALF_W] == '0));
    assert_scalar_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scalar_mode && size_fld != 2'b11) |=> undef);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(undef)));
endmodule

bind simd_lane_negate neg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .scalar_mode (scalar_mode),
    .size_fld    (size_fld),
    .q_fld       (q_fld),
    .out_valid   (out_valid),
    .result      (result),
    .undef       (undef)
);

// File: tb/tb_simd_lane_negate.sv
module tb_simd_lane_negate;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         scalar_mode = 1'b0;
    logic [1:0]   size_fld = 2'b00;
    logic         q_fld = 1'b0;
    logic [127:0] operand = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         undef;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_lane_negate dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .scalar_mode(scalar_mode),
        .size_fld(size_fld), .q_fld(q_fld), .operand(operand),
        .out_valid(out_valid), .result(result), .undef(undef)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: lane-wise (0 - x) mod 2^w over the active bits.
    function automatic logic [127:0] ref_neg(input logic [127:0] op, input int w, input int act);
        logic [127:0] r = '0;
        logic [127:0] m = {128{1'b1}} >> (128 - w);
        for (int e = 0; e < act / w; e++) begin
            logic [127:0] l;
            l = (op >> (e * w)) & m;
            r = r | ((((~l) + 128'd1) & m) << (e * w));
        end
        return r;
    endfunction

    // One bit pattern repeated in every lane of width w.
    function automatic logic [127:0] per_lane(input logic [127:0] v, input int w);
        logic [127:0] r = '0;
        for (int e = 0; e < 128 / w; e++) r = r | (v << (e * w));
        return r;
    endfunction

    task automatic run_one(input bit sc, input logic [1:0] sz, input bit q, input logic [127:0] op);
        int w;
        int act;
        bit exp_u;
        logic [127:0] exp_r;
        logic [127:0] prev;
        w     = 8 << sz;
        exp_u = sc ? (sz != 2'b11) : (sz == 2'b11 && !q);
        act   = sc ? 64 : (q ? 128 : 64);
        exp_r = exp_u ? '0 : ref_neg(op, w, act);
        @(negedge clk);
        in_valid = 1'b1; scalar_mode = sc; size_fld = sz; q_fld = q; operand = op;
        @(negedge clk);
        chk(out_valid == 1'b1, "R8 out_valid", 128'(out_valid), 128'd1);
        if (exp_u)
            chk(undef == 1'b1 && result == '0, sc ? "R7 scalar illegal" : "R5 reserved", result, exp_r);
        else if (sc)
            chk(undef == 1'b0 && result == exp_r, "R6 scalar negate", result, exp_r);
        else if (q)
            chk(undef == 1'b0 && result == exp_r, "R4 R2 R1 wide negate", result, exp_r);
        else
            chk(undef == 1'b0 && result == exp_r, "R3 R2 R1 narrow negate", result, exp_r);
        // R10: idle cycle with a changed operand must not disturb the outputs.
        prev = result;
        in_valid = 1'b0; operand = ~op;
        @(negedge clk);
        chk(out_valid == 1'b0 && result == prev && undef == exp_u, "R10 hold", result, prev);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && undef == 1'b0 && result == '0, "R9 reset", result, '0);
        rst_n = 1'b1;
        for (int sc = 0; sc < 2; sc++)
            for (int sz = 0; sz < 4; sz++)
                for (int q = 0; q < 2; q++) begin
                    int w;
                    w = 8 << sz;
                    run_one(sc[0], sz[1:0], q[0], '0);
                    run_one(sc[0], sz[1:0], q[0], {128{1'b1}});
                    run_one(sc[0], sz[1:0], q[0], per_lane(128'd1 << (w - 1), w));  // R2 sign bit only
                    run_one(sc[0], sz[1:0], q[0], per_lane(128'd1, w));
                    for (int k = 0; k < 12; k++)
                        run_one(sc[0], sz[1:0], q[0], {$urandom, $urandom, $urandom, $urandom});
                end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule